// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block sits on the host side of an 8-bit raw NAND device and carries out page reads. A request names an area of the page (lower half of the main array, upper half of the main array, or the spare bytes), a column offset within that area, a 16-bit page (row) address and a page count. The sequencer then drives the device strobes. It sends one command byte with the command-latch line high and three address bytes with the address-latch line high, each on a write-enable pulse. It waits for the ready/busy line while the device loads the page. It then pulses read-enable once per byte and hands each byte to a valid/ready stream.

When more than one page is asked for, the read continues into the following pages without a new command. The sequencer waits out the load time before each page. It never lets the read pass the end of a block: the page count is cut to the pages left in the block, and chip enable goes high after the last byte. All strobe widths and the wait before ready is trusted are counted in system clocks and set by parameters.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is held, chip enable, write enable and read enable are high (inactive), both latch lines are low, `outValid` is low and `reqReady` is high.
- R2: The command byte is driven while `nandCle` is high and latched on the rising edge of `nandWeN`. The byte is 8'h00 for area code 0, 8'h01 for area code 1, and 8'h50 for area codes 2 and 3.
- R3: The command is followed by exactly three write-enable pulses with `nandAle` high. They carry, in order, the request column byte unchanged, row bits 7:0 and row bits 15:8.
- R4: After the third address byte and after the last byte of every page, `nandReN` does not fall until a wait of BUSY_DLY clocks has passed and the synchronised ready/busy input reads ready (1).
- R5: The first page is streamed from its start column to column MAIN_BYTES+SPARE_BYTES-1. For area 0 the start is the column byte modulo MAIN_BYTES/2. For area 1 it is MAIN_BYTES/2 plus that value. For areas 2 and 3 it is MAIN_BYTES plus the column byte modulo SPARE_BYTES.
- R6: Every later page of the same request streams from column 0 for areas 0 and 1, and from column MAIN_BYTES for areas 2 and 3, through to the last column.
- R7: The number of pages read is the smaller of max(reqPages,1) and BLOCK_PAGES minus (row modulo BLOCK_PAGES). `outLast` is set on the final byte only, and chip enable goes high after that byte.
- R8: A byte presented with `outValid` high holds `outData` and `outLast` until `outReady` is high. No byte is lost or duplicated under back-pressure.
- R9: Each read-enable low phase lasts RE_LOW clocks, and the byte is captured on its last low clock. Each write-enable low phase lasts WE_LOW clocks.
- R10: Chip enable stays low without a break from the command byte until the final byte of the request, including every busy wait.
- R11: `reqReady` is high only while the sequencer is idle with chip enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Request accepted on this clock when valid |
| reqArea | input | 2 | 0 lower main half, 1 upper main half, 2/3 spare |
| reqCol | input | 8 | Column offset within the area |
| reqRow | input | 16 | Page address |
| reqPages | input | PG_W | Pages to read (0 treated as 1) |
| outValid | output | 1 | Read byte available |
| outReady | input | 1 | Consumer takes the byte |
| outData | output | 8 | Read byte |
| outLast | output | 1 | Final byte of the request |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandIoOut | output | 8 | Command/address byte to the device |
| nandIoOe | output | 1 | Drive enable for `nandIoOut` |
| nandIoIn | input | 8 | Data byte from the device |
| nandRdy | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
The hardest case to reach is a multi-page read that begins in the last pages of a block. There, the clamped page count, the busy wait between pages and a stalled consumer all meet on the final bytes. The bench uses a small geometry: 4-page blocks and 40-byte pages. It sweeps every area code and column values that do and do not need masking. It uses rows at each offset inside a block and page counts of zero, within the block and past its end, under several ready patterns. A device model answers each read-enable fall with a byte computed from row and column, and flags any read-enable fall while it is busy.

// File: rtl/nprd_pkg.sv
package nprd_pkg;

  typedef enum logic [1:0] {
    IO_CMD,
    IO_COL,
    IO_ROWLO,
    IO_ROWHI
  } ioSel_e;

  // control -> datapath
  typedef struct packed {
    logic   capture;
    ioSel_e ioSel;
    logic   sampleByte;
    logic   nextPage;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pageDone;
    logic lastPage;
    logic outFree;
  } dpStatus_t;

endpackage

// File: rtl/nprd_datapath.sv
module nprd_datapath
  import nprd_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int BLOCK_PAGES = 32,
  parameter logic [7:0] CMD_FIRST  = 8'h00,
  parameter logic [7:0] CMD_SECOND = 8'h01,
  parameter logic [7:0] CMD_SPARE  = 8'h50,
  parameter int PG_W = $clog2(BLOCK_PAGES) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  output dpStatus_t       status,
  input  logic [1:0]      reqArea,
  input  logic [7:0]      reqCol,
  input  logic [15:0]     reqRow,
  input  logic [PG_W-1:0] reqPages,
  output logic [7:0]      ioOut,
  input  logic [7:0]      ioIn,
  output logic            outValid,
  output logic [7:0]      outData,
  output logic            outLast,
  input  logic            outReady
);

  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES + 1);
  localparam int BLK_W      = $clog2(BLOCK_PAGES);
  localparam logic [7:0]       HALF_MASK  = 8'(MAIN_BYTES / 2 - 1);
  localparam logic [7:0]       SPARE_MASK = 8'(SPARE_BYTES - 1);
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(MAIN_BYTES / 2);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(MAIN_BYTES);
  localparam logic [COL_W-1:0] PAGE_END   = COL_W'(PAGE_BYTES);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [PG_W-1:0]  ONE_PAGE   = PG_W'(1);

  logic [1:0]       areaQ;
  logic [7:0]       colQ;
  logic [15:0]      rowQ;
  logic [COL_W-1:0] colPtr;
  logic [PG_W-1:0]  pagesLeft;

  logic [COL_W-1:0] startCol;
  logic [PG_W-1:0]  roomInBlock;
  logic [PG_W-1:0]  wantPages;
  logic [PG_W-1:0]  firstPages;

  always_comb begin
    if (reqArea[1])      startCol = SPARE_BASE + COL_W'(reqCol & SPARE_MASK);
    else if (reqArea[0]) startCol = HALF_BASE + COL_W'(reqCol & HALF_MASK);
    else                 startCol = COL_W'(reqCol & HALF_MASK);
    roomInBlock = PG_W'(BLOCK_PAGES) - PG_W'(reqRow[BLK_W-1:0]);
    wantPages   = (reqPages == '0) ? ONE_PAGE : reqPages;
    firstPages  = (wantPages < roomInBlock) ? wantPages : roomInBlock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      areaQ     <= '0;
      colQ      <= '0;
      rowQ      <= '0;
      colPtr    <= '0;
      pagesLeft <= '0;
    end else if (strobe.capture) begin
      areaQ     <= reqArea;
      colQ      <= reqCol;
      rowQ      <= reqRow;
      colPtr    <= startCol;
      pagesLeft <= firstPages;
    end else if (strobe.nextPage) begin
      colPtr    <= areaQ[1] ? SPARE_BASE : '0;
      pagesLeft <= pagesLeft - ONE_PAGE;
    end else if (strobe.sampleByte) begin
      colPtr    <= colPtr + 1'b1;
    end
  end

  always_comb begin
    case (strobe.ioSel)
      IO_CMD:   ioOut = areaQ[1] ? CMD_SPARE : (areaQ[0] ? CMD_SECOND : CMD_FIRST);
      IO_COL:   ioOut = colQ;
      IO_ROWLO: ioOut = rowQ[7:0];
      default:  ioOut = rowQ[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else if (strobe.sampleByte) begin
      outValid <= 1'b1;
      outData  <= ioIn;
      outLast  <= (colPtr == LAST_COL) && (pagesLeft == ONE_PAGE);
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assign status.pageDone = (colPtr == PAGE_END);
  assign status.lastPage = (pagesLeft == ONE_PAGE);
  assign status.outFree  = !outValid || outReady;

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleByte |-> !outValid);

  p_col_in_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleByte |-> (colPtr < PAGE_END));

endmodule

// File: rtl/nprd_ctrl.sv
module nprd_ctrl
  import nprd_pkg::*;
#(
  parameter int WE_LOW   = 2,
  parameter int WE_HIGH  = 2,
  parameter int RE_LOW   = 3,
  parameter int RE_HIGH  = 2,
  parameter int BUSY_DLY = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        nandRdyIn,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic        nandIoOe
);

  localparam int M_WE  = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int M_RE  = (RE_LOW > RE_HIGH) ? RE_LOW : RE_HIGH;
  localparam int M_STR = (M_WE > M_RE) ? M_WE : M_RE;
  localparam int T_MAX = (M_STR > BUSY_DLY) ? M_STR : BUSY_DLY;
  localparam int TW    = $clog2(T_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_LO, S_CMD_HI, S_ADR_LO, S_ADR_HI,
    S_WAIT_BSY, S_WAIT_RDY, S_RE_LO, S_RE_HI, S_DONE
  } state_e;

  state_e        state, stateNx;
  logic [TW-1:0] timer, timerNx;
  logic [1:0]    addrIdx, addrIdxNx;
  logic [1:0]    rdySync;
  logic          timerDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timer   <= '0;
      addrIdx <= '0;
      rdySync <= '0;
    end else begin
      state   <= stateNx;
      timer   <= timerNx;
      addrIdx <= addrIdxNx;
      rdySync <= {rdySync[0], nandRdyIn};
    end
  end

  assign timerDone = (timer == '0);

  always_comb begin
    stateNx   = state;
    timerNx   = timerDone ? timer : timer - 1'b1;
    addrIdxNx = addrIdx;
    strobe    = '0;
    strobe.ioSel = IO_CMD;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNx = S_CMD_LO;
        timerNx = TW'(WE_LOW - 1);
      end
      S_CMD_LO: if (timerDone) begin
        stateNx = S_CMD_HI;
        timerNx = TW'(WE_HIGH - 1);
      end
      S_CMD_HI: if (timerDone) begin
        stateNx   = S_ADR_LO;
        timerNx   = TW'(WE_LOW - 1);
        addrIdxNx = '0;
      end
      S_ADR_LO, S_ADR_HI: begin
        case (addrIdx)
          2'd0:    strobe.ioSel = IO_COL;
          2'd1:    strobe.ioSel = IO_ROWLO;
          default: strobe.ioSel = IO_ROWHI;
        endcase
        if (timerDone) begin
          if (state == S_ADR_LO) begin
            stateNx = S_ADR_HI;
            timerNx = TW'(WE_HIGH - 1);
          end else if (addrIdx == 2'd2) begin
            stateNx = S_WAIT_BSY;
            timerNx = TW'(BUSY_DLY - 1);
          end else begin
            stateNx   = S_ADR_LO;
            timerNx   = TW'(WE_LOW - 1);
            addrIdxNx = addrIdx + 1'b1;
          end
        end
      end
      S_WAIT_BSY: if (timerDone) stateNx = S_WAIT_RDY;
      S_WAIT_RDY: if (rdySync[1] && status.outFree) begin
        stateNx = S_RE_LO;
        timerNx = TW'(RE_LOW - 1);
      end
      S_RE_LO: if (timerDone) begin
        strobe.sampleByte = 1'b1;
        stateNx = S_RE_HI;
        timerNx = TW'(RE_HIGH - 1);
      end
      S_RE_HI: if (timerDone) begin
        if (status.pageDone && status.lastPage) begin
          stateNx = S_DONE;
        end else if (status.outFree) begin
          if (status.pageDone) begin
            strobe.nextPage = 1'b1;
            stateNx = S_WAIT_BSY;
            timerNx = TW'(BUSY_DLY - 1);
          end else begin
            stateNx = S_RE_LO;
            timerNx = TW'(RE_LOW - 1);
          end
        end
      end
      S_DONE:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign nandCeN  = (state == S_IDLE) || (state == S_DONE);
  assign nandCle  = (state == S_CMD_LO) || (state == S_CMD_HI);
  assign nandAle  = (state == S_ADR_LO) || (state == S_ADR_HI);
  assign nandWeN  = !((state == S_CMD_LO) || (state == S_ADR_LO));
  assign nandReN  = (state != S_RE_LO);
  assign nandIoOe = nandCle || nandAle;

  // low-phase length counter for the read strobe check
  logic [TW-1:0] reLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         reLowCnt <= '0;
    else if (!nandReN) reLowCnt <= reLowCnt + 1'b1;
    else               reLowCnt <= '0;
  end

  p_re_after_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |-> $past(rdySync[1]));

  p_addr_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandAle) |-> (addrIdx == 2'd2));

  p_ce_rise_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandCeN) |-> $past(status.pageDone && status.lastPage));

  p_re_width_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> (reLowCnt >= TW'(RE_LOW)));

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> nandCeN);

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nprd_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int BLOCK_PAGES = 32,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int RE_LOW      = 3,
  parameter int RE_HIGH     = 2,
  parameter int BUSY_DLY    = 10,
  parameter int PG_W        = $clog2(BLOCK_PAGES) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [1:0]      reqArea,
  input  logic [7:0]      reqCol,
  input  logic [15:0]     reqRow,
  input  logic [PG_W-1:0] reqPages,
  output logic            outValid,
  input  logic            outReady,
  output logic [7:0]      outData,
  output logic            outLast,
  output logic            nandCeN,
  output logic            nandCle,
  output logic            nandAle,
  output logic            nandWeN,
  output logic            nandReN,
  output logic [7:0]      nandIoOut,
  output logic            nandIoOe,
  input  logic [7:0]      nandIoIn,
  input  logic            nandRdy
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  nprd_ctrl #(
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW),
    .RE_HIGH(RE_HIGH), .BUSY_DLY(BUSY_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .nandRdyIn(nandRdy), .status(status), .strobe(strobe),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandIoOe(nandIoOe)
  );

  nprd_datapath #(
    .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .BLOCK_PAGES(BLOCK_PAGES), .PG_W(PG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqArea(reqArea), .reqCol(reqCol), .reqRow(reqRow), .reqPages(reqPages),
    .ioOut(nandIoOut), .ioIn(nandIoIn),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outReady(outReady)
  );

endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;

  localparam int MAIN = 32, SPARE = 8, BLOCK = 4;
  localparam int WE_LOW = 2, WE_HIGH = 1, RE_LOW = 2, RE_HIGH = 2, BUSY_DLY = 6;
  localparam int PAGE = MAIN + SPARE;
  localparam int PG_W = $clog2(BLOCK) + 1;
  localparam int LOAD = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqArea = '0;
  logic [7:0] reqCol = '0;
  logic [15:0] reqRow = '0;
  logic [PG_W-1:0] reqPages = '0;
  logic outValid, outReady = 1'b1, outLast;
  logic [7:0] outData;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0] nandIoOut;
  logic [7:0] nandIoIn = '0;
  logic nandRdy = 1'b1;

  nand_page_reader #(
    .MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .BLOCK_PAGES(BLOCK),
    .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RE_LOW(RE_LOW), .RE_HIGH(RE_HIGH),
    .BUSY_DLY(BUSY_DLY), .PG_W(PG_W)
  ) u_dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(int row, int col);
    return 8'(((row * 37) + (col * 11)) ^ (col >> 2) ^ 'h5a);
  endfunction

  // ---------------- device model ----------------
  logic [7:0] mCmd = '0;
  logic [7:0] mAddr [3];
  int mAddrCnt = 0, mRow = 0, mCol = 0, mRestart = 0;
  int mStartDelay = 0, mBusyLeft = 0, reEarly = 0;
  bit mRdy = 1, prevWe = 1, prevRe = 1;
  logic [7:0] mData = '0;

  always @(posedge clk) begin
    if (nandCeN) begin
      mStartDelay = 0;
      mRdy = 1;
    end else if (mStartDelay > 0) begin
      mStartDelay--;
      if (mStartDelay == 0) begin mRdy = 0; mBusyLeft = LOAD; end
    end else if (!mRdy) begin
      mBusyLeft--;
      if (mBusyLeft == 0) mRdy = 1;
    end
    if (!prevWe && nandWeN && !nandCeN) begin
      if (nandCle) begin
        mCmd = nandIoOut; mAddrCnt = 0;
      end else if (nandAle) begin
        if (mAddrCnt < 3) mAddr[mAddrCnt] = nandIoOut;
        mAddrCnt++;
        if (mAddrCnt == 3) begin
          mRow = {mAddr[2], mAddr[1]};
          if (mCmd == 8'h50)      begin mCol = MAIN + (mAddr[0] & (SPARE-1)); mRestart = MAIN; end
          else if (mCmd == 8'h01) begin mCol = MAIN/2 + (mAddr[0] & (MAIN/2-1)); mRestart = 0; end
          else                    begin mCol = mAddr[0] & (MAIN/2-1); mRestart = 0; end
          mStartDelay = 2;
        end
      end
    end
    if (prevRe && !nandReN) begin
      if (!mRdy || mStartDelay > 0) reEarly++;
      mData = pattern(mRow, mCol);
      mCol++;
    end
    if (!prevRe && nandReN && !nandCeN && mCol >= PAGE) begin
      mRow++; mCol = mRestart; mStartDelay = 2;
    end
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  always @(negedge clk) begin
    nandIoIn <= mData;
    nandRdy  <= mRdy;
  end

  // ---------------- consumer and monitors ----------------
  int readyMode = 0, cyc = 0;
  int expRow = 0, expCol = 0, expRestart = 0, expPageIdx = 0;
  int got = 0, lastAt = -1, lastCount = 0;
  int mismFirst = 0, mismLater = 0, firstAct = 0, firstExp = 0;
  int stabErr = 0, readyErr = 0, ceErr = 0, reLow = 0, minReLow = 1000, expBytes = 0;
  bit holdPrev = 0, active = 0;
  logic [7:0] holdData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      outReady = (readyMode == 0) ? 1'b1 : ((cyc % readyMode) != 0);
      if (holdPrev && (!outValid || outData != holdData)) stabErr++;
      holdPrev = outValid && !outReady;
      holdData = outData;
      if (outValid && outReady) begin
        got++;
        if (outData != pattern(expRow, expCol)) begin
          if (mismFirst + mismLater == 0) begin firstAct = outData; firstExp = pattern(expRow, expCol); end
          if (expPageIdx == 0) mismFirst++; else mismLater++;
        end
        if (outLast) begin lastCount++; lastAt = got; end
        expCol++;
        if (expCol == PAGE) begin expCol = expRestart; expRow++; expPageIdx++; end
      end
      if (!nandCeN && reqReady) readyErr++;
      if (active && nandCeN && got < expBytes) ceErr++;
      if (!nandReN) reLow++;
      else begin
        if (reLow > 0 && reLow < minReLow) minReLow = reLow;
        reLow = 0;
      end
    end
  end

  task automatic runReq(int area, int col, int row, int pages, int rmode);
    int eff, room, start, restart, guard;
    logic [7:0] expCmd;
    eff = (pages == 0) ? 1 : pages;
    room = BLOCK - (row % BLOCK);
    if (eff > room) eff = room;
    if (area >= 2)      begin start = MAIN + (col & (SPARE-1)); restart = MAIN; expCmd = 8'h50; end
    else if (area == 1) begin start = MAIN/2 + (col & (MAIN/2-1)); restart = 0; expCmd = 8'h01; end
    else                begin start = col & (MAIN/2-1); restart = 0; expCmd = 8'h00; end
    @(negedge clk);
    expBytes = (PAGE - start) + (eff - 1) * (PAGE - restart);
    expRow = row; expCol = start; expRestart = restart; expPageIdx = 0;
    got = 0; lastAt = -1; lastCount = 0; mismFirst = 0; mismLater = 0;
    stabErr = 0; readyErr = 0; ceErr = 0; reEarly = 0; minReLow = 1000; mAddrCnt = 0;
    readyMode = rmode;
    reqArea = 2'(area); reqCol = 8'(col); reqRow = 16'(row); reqPages = PG_W'(pages);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    active = 1;
    guard = 0;
    while (!(got == expBytes && nandCeN && reqReady) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    active = 0;
    repeat (12) @(negedge clk);
    check(mCmd == expCmd, "R2", "command byte", mCmd, expCmd);
    check(mAddrCnt == 3 && mAddr[0] == 8'(col) && mAddr[1] == 8'(row) && mAddr[2] == 8'(row >> 8),
          "R3", "address cycles", mAddrCnt, 3);
    check(reEarly == 0, "R4", "read strobes while busy", reEarly, 0);
    check(mismFirst == 0, "R5", "first page data", firstAct, firstExp);
    check(mismLater == 0, "R6", "later page data", firstAct, firstExp);
    check(got == expBytes, "R7", "byte count", got, expBytes);
    check(lastAt == expBytes && lastCount == 1, "R7", "last flag position", lastAt, expBytes);
    check(nandCeN, "R7", "chip enable high after read", nandCeN, 1);
    check(stabErr == 0, "R8", "held output changed", stabErr, 0);
    check(minReLow >= RE_LOW, "R9", "read strobe low width", minReLow, RE_LOW);
    check(ceErr == 0, "R10", "chip enable gap", ceErr, 0);
    check(readyErr == 0, "R11", "ready while active", readyErr, 0);
  endtask

  initial begin
    int rows [4];
    int cols [3];
    int pgs [3];
    int n;
    rows = '{0, 6, 7, 261};
    cols = '{0, 3, 200};
    pgs = '{0, 2, 5};
    repeat (3) @(negedge clk);
    check(nandCeN && nandWeN && nandReN && !nandCle && !nandAle, "R1", "strobes in reset",
          {nandCeN, nandWeN, nandReN, nandCle, nandAle}, 5'b11100);
    check(!outValid && reqReady, "R1", "handshake in reset", {outValid, reqReady}, 2'b01);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    n = 0;
    for (int a = 0; a < 4; a++)
      for (int ci = 0; ci < 3; ci++)
        for (int ri = 0; ri < 4; ri++)
          for (int pi = 0; pi < 3; pi++) begin
            runReq(a, cols[ci], rows[ri], pgs[pi], (n % 4 == 0) ? 0 : (n % 4) + 1);
            n++;
          end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule